// File: doc/BRIEF.md
# Indexed Codec Register Port

This block is the host-side register front end of an audio codec. A byte-wide port with four direct addresses gives software an index pointer, a data window, an interrupt status byte and a parallel-data byte. The data window reaches a bank of indirect byte registers through the pointer. The block enforces the access rules of that bank: reset values, registers that cannot be written, a mode bit that widens the pointer from 16 to 32 registers, and a guarded playback format register.

Downstream logic sees every indirect register on a flat output bus. A one-cycle strobe marks each accepted change of the format register, and its current value is held on a separate output. An end-of-playback pulse from the audio datapath raises the interrupt. After the mode-change enable rises, a short calibration window is shown to software as a flag in the error/initialisation register.

There is no back-pressure anywhere. Each access completes in the cycle its strobe is high: writes take effect at that clock edge, and read data is combinational while `bus_rd` is high. One access per cycle is expected.

Top module: `codec_regport`

## Requirements
- R1: After reset the pointer reads 0x40 and status reads 0x00. Indirect registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80, register 9 reads 0x08 and register 12 reads 0x8A. Registers 25 and 26 read 0xA0, and all other registers read 0x00.
- R2: A write to direct address 0 stores bits 6:0 and drops bit 7, so a read of address 0 always returns bit 7 as 0. Bit 6 of the pointer is the mode-change enable.
- R3: Direct address 1 selects indirect register `pointer[3:0]` when bit 6 of register 12 is 0, and `pointer[4:0]` when that bit is 1.
- R4: Writes to registers 11, 22, 27 and 29 leave them unchanged. A write to register 12 changes only its bit 6.
- R5: A write to register 9 stores the data with bit 5 forced to 0.
- R6: A write to register 8 stores the full byte when the mode-change enable is set. Otherwise, if bit 4 of register 24 is set, it stores the upper nibble and keeps the old lower nibble. Otherwise the write is discarded.
- R7: `fmt_upd` is high for exactly the one cycle after each accepted register 8 write, and never otherwise. `fmt_value` always shows register 8.
- R8: A pointer write that takes the mode-change enable from 0 to 1 while bits 4:3 of register 9 are not both 0 arms a counter with CAL_READS. While the counter is nonzero, each read of register 11 returns bit 5 set and decrements the counter. With the counter at zero, register 11 reads its stored value.
- R9: Any write to direct address 2 clears the interrupt (status bit 0, `irq`) and bits 6:4 of register 24.
- R10: A `pb_done` pulse sets the interrupt and bit 4 of register 24. It wins over a status write in the same cycle.
- R11: A write to register 24 that takes its bit 4 from 1 to 0 clears the interrupt.
- R12: Direct address 3 ignores writes and always reads 0x00. Status bits 7:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Direct address: 0 pointer, 1 data, 2 status, 3 parallel data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; advances the calibration counter |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| pb_done | input | 1 | End-of-playback event pulse |
| irq | output | 1 | Interrupt, equal to status bit 0 |
| fmt_upd | output | 1 | One-cycle pulse after an accepted format write |
| fmt_value | output | DW | Current format register |
| regs_flat | output | NREG*DW | All indirect registers, register n at bits n*DW +: DW |

## Verification
The hardest state to reach is the calibration window. It needs a 0-to-1 transition of the enable bit, and that transition only counts while register 9 has bits 4:3 set, which reset already provides. Reads must then land on register 11 through a pointer that is masked according to the mode bit. The bench drives this directly: it arms the window, counts reads across its end, and checks that a second enable write with the bit already set does not re-arm it. Random pointer and data writes, which toggle the mode bit and register 9 freely, then revisit the window against a bench model.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;
  localparam logic [1:0] A_INDEX = 2'd0;
  localparam logic [1:0] A_DATA  = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;
  localparam logic [1:0] A_PIO   = 2'd3;

  localparam int unsigned IR_FMT  = 8;
  localparam int unsigned IR_CFG  = 9;
  localparam int unsigned IR_CAL  = 11;
  localparam int unsigned IR_MODE = 12;
  localparam int unsigned IR_AFS  = 24;

  localparam int unsigned MODE_BIT = 6;
  localparam int unsigned PI_BIT   = 4;
  localparam int unsigned CAL_BIT  = 5;

  localparam logic [7:0] IDX_RESET = 8'h40;

  function automatic logic [7:0] ireg_reset(int unsigned n);
    case (n)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic ireg_locked(int unsigned n);
    return (n == 11) || (n == 22) || (n == 27) || (n == 29);
  endfunction
endpackage

// File: rtl/codec_idx_decode.sv
module codec_idx_decode #(
  parameter int unsigned IW = 5
) (
  input  logic [IW-1:0] idx_raw,
  input  logic          wide,
  output logic [IW-1:0] idx_eff
);
  always_comb begin
    idx_eff = idx_raw;
    if (!wide) idx_eff[IW-1] = 1'b0;
  end
endmodule

// File: rtl/codec_cal_timer.sv
module codec_cal_timer #(
  parameter int unsigned CAL_READS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic busy
);
  localparam int unsigned CW = $clog2(CAL_READS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= CW'(CAL_READS);
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/codec_ireg_bank.sv
module codec_ireg_bank
  import codec_regport_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  input  logic               mce,
  input  logic               sta_clr,
  input  logic               pb_done,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               fmt_accept,
  output logic               pi_fall
);
  logic afs_pi;
  assign afs_pi = regs_flat[IR_AFS*DW + PI_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q, nxt;
    logic          hit;
    assign hit = wr_en && (idx == IW'(g));

    if (g == IR_FMT) begin : g_fmt
      always_comb begin
        nxt = q;
        if (hit) begin
          if (mce)         nxt = wdata;
          else if (afs_pi) nxt = {wdata[DW-1:4], q[3:0]};
        end
      end
    end else if (g == IR_CFG) begin : g_cfg
      always_comb begin
        nxt = q;
        if (hit) begin
          nxt = wdata;
          nxt[5] = 1'b0;
        end
      end
    end else if (g == IR_MODE) begin : g_mode
      always_comb begin
        nxt = q;
        if (hit) nxt[MODE_BIT] = wdata[MODE_BIT];
      end
    end else if (g == IR_AFS) begin : g_afs
      always_comb begin
        nxt = q;
        if (hit)     nxt = wdata;
        if (sta_clr) nxt[6:4] = 3'b000;
        if (pb_done) nxt[PI_BIT] = 1'b1;
      end
    end else if (ireg_locked(g)) begin : g_lock
      assign nxt = q;
    end else begin : g_plain
      assign nxt = hit ? wdata : q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= DW'(ireg_reset(g));
      else        q <= nxt;
    end

    assign regs_flat[g*DW +: DW] = q;
  end

  assign fmt_accept = wr_en && (idx == IW'(IR_FMT)) && (mce || afs_pi);
  assign pi_fall    = wr_en && (idx == IW'(IR_AFS)) && afs_pi && !wdata[PI_BIT];
endmodule

// File: rtl/codec_regport.sv
module codec_regport
  import codec_regport_pkg::*;
#(
  parameter int unsigned NREG      = 32,
  parameter int unsigned DW        = 8,
  parameter int unsigned CAL_READS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               pb_done,
  output logic               irq,
  output logic               fmt_upd,
  output logic [DW-1:0]      fmt_value,
  output logic [NREG*DW-1:0] regs_flat
);
  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned XW = DW - 1;

  logic [XW-1:0] idx_q;
  logic          mce, mode2, int_q, fmt_upd_q;
  logic [IW-1:0] idx_eff;
  logic          wr_idx, wr_dat, sta_clr, cal_load, cal_dec, cal_busy;
  logic          fmt_accept, pi_fall;
  logic [DW-1:0] reg_arr [NREG];

  assign mce     = idx_q[MODE_BIT];
  assign wr_idx  = bus_wr && (bus_addr == A_INDEX);
  assign wr_dat  = bus_wr && (bus_addr == A_DATA);
  assign sta_clr = bus_wr && (bus_addr == A_STAT);

  for (genvar g = 0; g < NREG; g++) begin : g_arr
    assign reg_arr[g] = regs_flat[g*DW +: DW];
  end

  assign mode2 = reg_arr[IR_MODE][MODE_BIT];

  codec_idx_decode #(.IW(IW)) u_dec (
    .idx_raw (idx_q[IW-1:0]),
    .wide    (mode2),
    .idx_eff (idx_eff)
  );

  codec_ireg_bank #(.NREG(NREG), .DW(DW), .IW(IW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_dat),
    .idx        (idx_eff),
    .wdata      (bus_wdata),
    .mce        (mce),
    .sta_clr    (sta_clr),
    .pb_done    (pb_done),
    .regs_flat  (regs_flat),
    .fmt_accept (fmt_accept),
    .pi_fall    (pi_fall)
  );

  assign cal_load = wr_idx && !mce && bus_wdata[MODE_BIT] && (reg_arr[IR_CFG][4:3] != 2'b00);
  assign cal_dec  = bus_rd && (bus_addr == A_DATA) && (idx_eff == IW'(IR_CAL));

  codec_cal_timer #(.CAL_READS(CAL_READS)) u_cal (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cal_load),
    .dec   (cal_dec),
    .busy  (cal_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= IDX_RESET[XW-1:0];
      int_q     <= 1'b0;
      fmt_upd_q <= 1'b0;
    end else begin
      if (wr_idx) idx_q <= bus_wdata[XW-1:0];
      if (pb_done)                 int_q <= 1'b1;
      else if (sta_clr || pi_fall) int_q <= 1'b0;
      fmt_upd_q <= fmt_accept;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_INDEX: bus_rdata = {1'b0, idx_q};
      A_DATA: begin
        bus_rdata = reg_arr[idx_eff];
        if ((idx_eff == IW'(IR_CAL)) && cal_busy) bus_rdata[CAL_BIT] = 1'b1;
      end
      A_STAT:  bus_rdata[0] = int_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq       = int_q;
  assign fmt_upd   = fmt_upd_q;
  assign fmt_value = reg_arr[IR_FMT];
endmodule

// File: rtl/codec_regport_chk.sv
module codec_regport_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic          pb_done,
  input logic          irq,
  input logic          fmt_upd,
  input logic          mce,
  input logic [IW-1:0] idx_eff,
  input logic [DW-1:0] r_fmt,
  input logic [DW-1:0] r_cfg,
  input logic [DW-1:0] r_cal,
  input logic [DW-1:0] r_afs
);
  logic dat_wr;
  assign dat_wr = bus_wr && (bus_addr == 2'd1);

  // R2
  p_idx_msb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |-> (bus_rdata < 8'h80));

  // R4
  p_ro_reg_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_eff == IW'(11)) |=> $stable(r_cal));

  // R5
  p_cfg_bit5_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_eff == IW'(9)) |=> ((r_cfg & 8'h20) == 8'h00));

  // R6
  p_fmt_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_eff == IW'(8) && !mce && !r_afs[4]) |=> ($stable(r_fmt) && !fmt_upd));

  // R7
  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_upd |-> $past(dat_wr && idx_eff == IW'(8)));

  // R9
  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !pb_done) |=> (!irq && ((r_afs & 8'h70) == 8'h00)));

  // R10
  p_pb_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pb_done |=> (irq && r_afs[4]));
endmodule

bind codec_regport codec_regport_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pb_done   (pb_done),
  .irq       (irq),
  .fmt_upd   (fmt_upd),
  .mce       (mce),
  .idx_eff   (idx_eff),
  .r_fmt     (reg_arr[8]),
  .r_cfg     (reg_arr[9]),
  .r_cal     (reg_arr[11]),
  .r_afs     (reg_arr[24])
);

// File: tb/codec_regport_bench.sv
`timescale 1ns/1ps
module codec_regport_bench;
  localparam int CAL = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0, pb_done = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata, fmt_value;
  logic         irq, fmt_upd;
  logic [255:0] regs_flat;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_reg [32];
  logic [6:0] m_idx;
  logic       m_int;
  int         m_cnt;

  always #2.5 clk = ~clk;

  codec_regport #(.NREG(32), .DW(8), .CAL_READS(CAL)) u_codec_regport (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pb_done(pb_done), .irq(irq),
    .fmt_upd(fmt_upd), .fmt_value(fmt_value), .regs_flat(regs_flat)
  );

  function automatic logic [7:0] exp_reset(int n);
    if (n == 6 || n == 7) return 8'h80;
    if (n == 25 || n == 26) return 8'hA0;
    if ((n >= 2 && n <= 5) || n == 18 || n == 19) return 8'h88;
    if (n == 9) return 8'h08;
    if (n == 12) return 8'h8A;
    return 8'h00;
  endfunction

  function automatic int eff_idx();
    return m_reg[12][6] ? int'(m_idx[4:0]) : int'(m_idx[3:0]);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [1:0] a, logic [7:0] d);
    bit acc;
    int i;
    acc = 0;
    case (a)
      2'd0: begin
        if (!m_idx[6] && d[6] && m_reg[9][4:3] != 2'b00) m_cnt = CAL;
        m_idx = d[6:0];
      end
      2'd1: begin
        i = eff_idx();
        case (i)
          11, 22, 27, 29: ;
          8: begin
            if (m_idx[6]) begin m_reg[8] = d; acc = 1; end
            else if (m_reg[24][4]) begin m_reg[8] = {d[7:4], m_reg[8][3:0]}; acc = 1; end
          end
          9:  m_reg[9] = d & 8'hDF;
          12: m_reg[12][6] = d[6];
          24: begin
            if (m_reg[24][4] && !d[4]) m_int = 0;
            m_reg[24] = d;
          end
          default: m_reg[i] = d;
        endcase
      end
      2'd2: begin m_int = 0; m_reg[24] = m_reg[24] & 8'h8F; end
      default: ;
    endcase
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7 strobe", {7'b0, fmt_upd}, {7'b0, acc});
    check("R7 fmt_value", fmt_value, m_reg[8]);
  endtask

  task automatic do_rd(logic [1:0] a, string tag);
    logic [7:0] e;
    int i;
    case (a)
      2'd0: e = {1'b0, m_idx};
      2'd1: begin
        i = eff_idx();
        e = m_reg[i];
        if (i == 11 && m_cnt > 0) begin e[5] = 1'b1; m_cnt--; end
      end
      2'd2: e = {7'b0, m_int};
      default: e = 8'h00;
    endcase
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(tag, bus_rdata, e);
    check("R10 irq", {7'b0, irq}, {7'b0, m_int});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_pb(bit with_clear);
    m_int = 1; m_reg[24][4] = 1'b1;
    pb_done = 1'b1;
    if (with_clear) begin bus_addr = 2'd2; bus_wr = 1'b1; end
    @(negedge clk);
    pb_done = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_ireg(int n, string tag);
    do_wr(2'd0, 8'(n));
    do_rd(2'd1, tag);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) m_reg[k] = exp_reset(k);
    m_idx = 7'h40; m_int = 0; m_cnt = 0;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    do_rd(2'd0, "R1 pointer reset");
    do_rd(2'd2, "R1 status reset");
    for (int k = 0; k < 16; k++) rd_ireg(k, "R1 low bank reset");
    do_wr(2'd0, 8'd12); do_wr(2'd1, 8'h40);
    for (int k = 16; k < 32; k++) rd_ireg(k, "R1 high bank reset");

    // R2 pointer bit 7
    do_wr(2'd0, 8'hFF); do_rd(2'd0, "R2 msb dropped");
    // R3 masking: wide mode reaches 24, narrow mode folds 0x18 onto 8
    rd_ireg(8'h18, "R3 wide index");
    do_wr(2'd0, 8'd12); do_wr(2'd1, 8'h00);
    rd_ireg(8'h18, "R3 narrow index");
    do_wr(2'd0, 8'h13); do_wr(2'd1, 8'h5C); rd_ireg(3, "R3 narrow write alias");
    do_wr(2'd0, 8'd12); do_wr(2'd1, 8'h40);
    // R4 protected registers
    do_wr(2'd0, 8'd22); do_wr(2'd1, 8'h55); do_rd(2'd1, "R4 reserved 22");
    do_wr(2'd0, 8'd29); do_wr(2'd1, 8'hAA); do_rd(2'd1, "R4 reserved 29");
    do_wr(2'd0, 8'd11); do_wr(2'd1, 8'hFF); do_rd(2'd1, "R4 read-only 11");
    do_wr(2'd0, 8'd12); do_wr(2'd1, 8'h3F); do_rd(2'd1, "R4 mode reg one bit");
    do_wr(2'd0, 8'd12); do_wr(2'd1, 8'h40);
    // R5 register 9
    do_wr(2'd0, 8'd9); do_wr(2'd1, 8'hFF); do_rd(2'd1, "R5 bit5 forced");
    // R6 format register guard
    do_wr(2'd0, 8'd8); do_wr(2'd1, 8'h5A); do_rd(2'd1, "R6 dropped");
    do_wr(2'd0, 8'd24); do_wr(2'd1, 8'h10);
    do_wr(2'd0, 8'd8); do_wr(2'd1, 8'hA7); do_rd(2'd1, "R6 upper nibble only");
    do_wr(2'd0, 8'h48); do_wr(2'd1, 8'h3C); do_rd(2'd1, "R6 full under enable");
    // R8 calibration window
    do_wr(2'd0, 8'd9); do_wr(2'd1, 8'h18);
    do_wr(2'd0, 8'h4B);
    for (int k = 0; k < CAL + 1; k++) do_rd(2'd1, "R8 calibration flag");
    do_wr(2'd0, 8'h4B); do_rd(2'd1, "R8 no rearm while set");
    do_wr(2'd0, 8'd9); do_wr(2'd1, 8'h00);
    do_wr(2'd0, 8'h4B); do_rd(2'd1, "R8 no arm when cfg zero");
    // R9 / R10 / R11 interrupt
    pulse_pb(0); do_rd(2'd2, "R10 pb sets int");
    do_wr(2'd2, 8'h00); do_rd(2'd2, "R9 status clear");
    rd_ireg(24, "R9 afs bits cleared");
    pulse_pb(1); do_rd(2'd2, "R10 pb wins over clear");
    do_wr(2'd0, 8'd24); do_wr(2'd1, 8'h00); do_rd(2'd2, "R11 pi fall clears int");
    // R12 parallel data
    do_wr(2'd3, 8'hC3); do_rd(2'd3, "R12 pio reads zero");

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: do_wr(2'd0, 8'($urandom_range(0, 255)));
        2, 3: do_wr(2'd1, 8'($urandom_range(0, 255)));
        4, 5: do_rd(2'd1, "R3 random data read");
        6:    do_rd(2'd0, "R2 random pointer read");
        7:    do_wr(2'd2, 8'($urandom_range(0, 255)));
        8:    pulse_pb($urandom_range(0, 1) == 1);
        default: do_rd(2'($urandom_range(2, 3)), "R12 random status read");
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule